// File: doc/BRIEF.md
# Gated-Count Frequency Lock Detector

The block watches an external oscillator and reports whether it has drifted above or below a frequency captured on request. A divider on the reference clock cuts time into gate intervals of a fixed number of cycles. Within each interval a narrow counter tallies the rising edges of the measured signal. This counter wraps freely, so the value it holds is the edge count modulo its width. At the close of every interval the finished tally is held in a register for one cycle, and the counter restarts from zero.

A rising edge on the lock request stores the tally of the interval in progress as the target. From then on, every finished tally is subtracted from the target in two's complement at the counter's width. The sign of that difference sets a one-bit steering output, meant for a leaky integrator that drives a tuning voltage. It also sets a pair of indicators that mark the oscillator as running fast or slow. The signed difference itself is available as a multi-bit error word, with its upper bits used for coarse steering and its lower bits for fine steering. A rising edge on the unlock request drops tracking and quiets every output.

Top module: `freq_lock_det`

## Requirements
- R1: A gate interval lasts exactly GATE_DIV reference cycles. The tally of an interval equals the number of rising edges of `meas_i` seen inside it, and the counter starts again from zero for the next interval.
- R2: The edge tally is CNT_W bits wide (12 by default) and wraps modulo 2^CNT_W. A wrapped tally still gives the correct sign whenever the true count differs from the target by less than 2^(CNT_W-1).
- R3: In the idle state, a rising edge on `lock_req_i` (after a two-flop synchronizer) arms the block. The tally of the interval in which the edge was seen becomes the target. Capturing the target changes no output. Lock request edges that arrive while armed or tracking have no effect on the target.
- R4: While tracking, each finished tally is evaluated one cycle after its interval closes, with diff = target − tally taken as a signed CNT_W-bit value. If diff > 0 (oscillator slow), then `freq_lo_o`=1, `freq_hi_o`=0 and `corr_o`=1.
- R5: If diff < 0 (oscillator fast), then `freq_hi_o`=1, `freq_lo_o`=0 and `corr_o`=0.
- R6: If diff = 0, both indicators go low and `corr_o` keeps its previous value.
- R7: `err_o` is loaded with diff at every evaluation while tracking. It reads 0 while idle.
- R8: A rising edge on `unlock_req_i` (synchronized) returns the block to idle from any state, and clears `corr_o`, `freq_hi_o`, `freq_lo_o` and `err_o`. While idle, no evaluation takes place. Unlock wins over a lock request or an evaluation in the same cycle.
- R9: After reset, all outputs are 0 and the block is idle.
- R10: Outputs change only in the cycle of an evaluation or of an unlock. Between evaluations they hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; sets the gate timing |
| rst_ni | input | 1 | Asynchronous active-low reset |
| meas_i | input | 1 | Oscillator being measured; must stay below half the reference rate |
| lock_req_i | input | 1 | Lock request, acts on its rising edge |
| unlock_req_i | input | 1 | Unlock request, acts on its rising edge |
| corr_o | output | 1 | Steering bit: 1 raises the frequency, 0 lowers it |
| freq_hi_o | output | 1 | Last evaluation found the oscillator fast |
| freq_lo_o | output | 1 | Last evaluation found the oscillator slow |
| err_o | output | CNT_W | Signed target minus current tally |

## Verification
The hardest condition to reach is an evaluation in which the raw tally has wrapped past the counter width, so that a plain magnitude compare would give the wrong sign. The bench uses a gate long enough that a pulse train with one pulse every two cycles overflows the 12-bit counter. It locks on that overflowed tally and then slows the train to one pulse every three cycles. This leaves the stored target numerically below the new tally, while the true frequency is lower, so the block must report slow. The bench picks every pulse period to divide the gate length exactly. Each steady interval then holds a known, exact count, and the expected error words follow directly from the periods.

// File: rtl/fld_pkg.sv
package fld_pkg;

  typedef enum logic [1:0] {
    LK_IDLE  = 2'd0,
    LK_ARM   = 2'd1,
    LK_TRACK = 2'd2
  } lk_state_e;

endpackage

// File: rtl/fld_rise_sync.sv
// Multi-flop synchronizer followed by a rising-edge detector.
module fld_rise_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);

  localparam int PW = STAGES + 1;

  logic [PW-1:0] pipe_q;
  logic [PW-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[PW-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

endmodule

// File: rtl/fld_gate_timer.sv
// Free-running divider; flags the last cycle of each gate interval.
module fld_gate_timer #(
  parameter int GATE_DIV = 400000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic gate_end_o
);

  localparam int DIV_W = (GATE_DIV > 1) ? $clog2(GATE_DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(GATE_DIV - 1);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;

  assign gate_end_o = (div_q == LAST);

  always_comb begin
    if (gate_end_o) div_d = '0;
    else            div_d = div_q + DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

endmodule

// File: rtl/fld_edge_counter.sv
// Wrapping edge tally per gate; finished tally latched with a valid pulse.
module fld_edge_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             gate_end_i,
  output logic [CNT_W-1:0] done_cnt_o,
  output logic             done_vld_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [CNT_W-1:0] done_q;
  logic             vld_q;

  always_comb begin
    cnt_inc = cnt_q + CNT_W'(rise_i);
    cnt_d   = gate_end_i ? '0 : cnt_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      vld_q <= gate_end_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         done_q <= '0;
    else if (gate_end_i) done_q <= cnt_inc;
  end

  assign done_cnt_o = done_q;
  assign done_vld_o = vld_q;

endmodule

// File: rtl/freq_lock_det.sv
module freq_lock_det #(
  parameter int GATE_DIV  = 400000,
  parameter int CNT_W     = 12,
  parameter int SYNC_STGS = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    meas_i,
  input  logic                    lock_req_i,
  input  logic                    unlock_req_i,
  output logic                    corr_o,
  output logic                    freq_hi_o,
  output logic                    freq_lo_o,
  output logic signed [CNT_W-1:0] err_o
);

  import fld_pkg::*;

  localparam int NREQ = 3;
  localparam int MSB  = CNT_W - 1;

  logic [NREQ-1:0] raw_in;
  logic [NREQ-1:0] rise_vec;
  logic            meas_rise, lock_rise, unlock_rise;
  logic            gate_end;
  logic [CNT_W-1:0] done_cnt;
  logic             done_vld;

  assign raw_in = {unlock_req_i, lock_req_i, meas_i};

  for (genvar g = 0; g < NREQ; g++) begin : g_sync
    fld_rise_sync #(.STAGES(SYNC_STGS)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw_in[g]),
      .rise_o (rise_vec[g])
    );
  end

  assign meas_rise   = rise_vec[0];
  assign lock_rise   = rise_vec[1];
  assign unlock_rise = rise_vec[2];

  fld_gate_timer #(.GATE_DIV(GATE_DIV)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gate_end_o (gate_end)
  );

  fld_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (meas_rise),
    .gate_end_i (gate_end),
    .done_cnt_o (done_cnt),
    .done_vld_o (done_vld)
  );

  lk_state_e        state_q, state_d;
  logic [CNT_W-1:0] target_q, target_d;
  logic             cap_en;
  logic             out_en;
  logic             corr_q, corr_d;
  logic             hi_q, hi_d;
  logic             lo_q, lo_d;
  logic [CNT_W-1:0] err_q, err_d;
  logic [CNT_W-1:0] diff;

  // modulo subtraction: wrapped tallies keep the correct sign within range
  assign diff = target_q - done_cnt;

  always_comb begin
    state_d  = state_q;
    target_d = target_q;
    cap_en   = 1'b0;
    out_en   = 1'b0;
    corr_d   = corr_q;
    hi_d     = hi_q;
    lo_d     = lo_q;
    err_d    = err_q;
    if (unlock_rise) begin
      state_d = LK_IDLE;
      out_en  = 1'b1;
      corr_d  = 1'b0;
      hi_d    = 1'b0;
      lo_d    = 1'b0;
      err_d   = '0;
    end else begin
      unique case (state_q)
        LK_IDLE: begin
          if (lock_rise) state_d = LK_ARM;
        end
        LK_ARM: begin
          if (done_vld) begin
            cap_en   = 1'b1;
            target_d = done_cnt;
            state_d  = LK_TRACK;
          end
        end
        LK_TRACK: begin
          if (done_vld) begin
            out_en = 1'b1;
            err_d  = diff;
            if (diff == '0) begin
              hi_d = 1'b0;
              lo_d = 1'b0;
            end else if (diff[MSB]) begin
              hi_d   = 1'b1;
              lo_d   = 1'b0;
              corr_d = 1'b0;
            end else begin
              hi_d   = 1'b0;
              lo_d   = 1'b1;
              corr_d = 1'b1;
            end
          end
        end
        default: state_d = LK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LK_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     target_q <= '0;
    else if (cap_en) target_q <= target_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      corr_q <= 1'b0;
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
      err_q  <= '0;
    end else if (out_en) begin
      corr_q <= corr_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      err_q  <= err_d;
    end
  end

  assign corr_o    = corr_q;
  assign freq_hi_o = hi_q;
  assign freq_lo_o = lo_q;
  assign err_o     = $signed(err_q);

endmodule

// File: rtl/freq_lock_det_chk.sv
module freq_lock_det_chk #(
  parameter int CNT_W = 12
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input fld_pkg::lk_state_e      state_q,
  input logic [CNT_W-1:0]        target_q,
  input logic [CNT_W-1:0]        done_cnt,
  input logic                    done_vld,
  input logic                    gate_end,
  input logic                    unlock_rise,
  input logic                    corr_o,
  input logic                    freq_hi_o,
  input logic                    freq_lo_o,
  input logic signed [CNT_W-1:0] err_o
);

  import fld_pkg::*;

  AST_GATE_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_end |=> !gate_end); // R1

  AST_HILO_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(freq_hi_o && freq_lo_o)); // R4

  AST_SLOW_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_lo_o |-> corr_o); // R4

  AST_FAST_LOWERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freq_hi_o |-> !corr_o); // R5

  AST_EQUAL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LK_TRACK && done_vld && !unlock_rise && done_cnt == target_q)
    |=> ($stable(corr_o) && !freq_hi_o && !freq_lo_o && err_o == '0)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LK_IDLE) |-> (!corr_o && !freq_hi_o && !freq_lo_o && err_o == '0)); // R8

  AST_UNLOCK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_rise |=> (state_q == LK_IDLE)); // R8

  AST_HOLD_BETWEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_vld && !unlock_rise)
    |=> ($stable(corr_o) && $stable(freq_hi_o) && $stable(freq_lo_o) && $stable(err_o))); // R10

endmodule

bind freq_lock_det freq_lock_det_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .state_q     (state_q),
  .target_q    (target_q),
  .done_cnt    (done_cnt),
  .done_vld    (done_vld),
  .gate_end    (gate_end),
  .unlock_rise (unlock_rise),
  .corr_o      (corr_o),
  .freq_hi_o   (freq_hi_o),
  .freq_lo_o   (freq_lo_o),
  .err_o       (err_o)
);

// File: tb/freq_lock_det_bench.sv
module freq_lock_det_bench;

  localparam int CLK_PERIOD = 10;
  localparam int G          = 8400;
  localparam int CW         = 12;
  localparam int WDOG       = 180000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic meas = 1'b0;
  logic lock_req = 1'b0;
  logic unlock_req = 1'b0;
  logic corr, fhi, flo;
  logic signed [CW-1:0] err;

  int cyc = 0;
  int period = 0;
  int ph = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  freq_lock_det #(.GATE_DIV(G), .CNT_W(CW), .SYNC_STGS(2)) u_freq_lock_det (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .meas_i       (meas),
    .lock_req_i   (lock_req),
    .unlock_req_i (unlock_req),
    .corr_o       (corr),
    .freq_hi_o    (fhi),
    .freq_lo_o    (flo),
    .err_o        (err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // one-cycle pulse every 'period' cycles; period divides G exactly
  always @(negedge clk) begin
    if (period < 2) begin
      meas <= 1'b0;
      ph   <= 0;
    end else begin
      meas <= (ph == 0);
      ph   <= (ph >= period - 1) ? 0 : ph + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_outs(input string tag, input int c, input int h, input int l, input int e);
    chk({tag, " corr"}, int'(corr), c);
    chk({tag, " hi"},   int'(fhi),  h);
    chk({tag, " lo"},   int'(flo),  l);
    chk({tag, " err"},  int'(err),  e);
  endtask

  // returns at the negedge just after the evaluation edge of a gate
  task automatic wait_update();
    do @(negedge clk); while (cyc % G != 1);
  endtask

  task automatic settle(input int p);
    period = p;
    wait_update();
    wait_update();
  endtask

  task automatic pulse_lock();
    lock_req = 1'b1;
    repeat (4) @(negedge clk);
    lock_req = 1'b0;
  endtask

  task automatic pulse_unlock();
    unlock_req = 1'b1;
    repeat (4) @(negedge clk);
    unlock_req = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk_outs("R9 in reset", 0, 0, 0, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_outs("R9 after reset", 0, 0, 0, 0);
  endtask

  task automatic t_track();
    settle(6);                       // 1400 edges per gate
    pulse_lock();
    wait_update();                   // target captured
    chk_outs("R3 capture silent", 0, 0, 0, 0);
    settle(5);                       // 1680: fast by 280
    chk_outs("R5 R7 R1 fast", 0, 1, 0, -280);
    repeat (200) @(negedge clk);
    chk_outs("R10 hold between", 0, 1, 0, -280);
    period = 7;                      // 1200: slow by 200
    wait_update();
    pulse_lock();                    // ignored while tracking
    wait_update();
    chk_outs("R4 R7 slow", 1, 0, 1, 200);
    settle(6);                       // equals target if it was kept
    chk_outs("R6 R3 equal holds", 1, 0, 0, 0);
  endtask

  task automatic t_unlock();
    pulse_unlock();
    repeat (4) @(negedge clk);
    chk_outs("R8 unlock clears", 0, 0, 0, 0);
    period = 5;
    wait_update();
    wait_update();
    chk_outs("R8 idle no eval", 0, 0, 0, 0);
  endtask

  task automatic t_wrap();
    settle(2);                       // 4200 edges, tally wraps to 104
    pulse_lock();
    wait_update();
    settle(3);                       // 2800: slow by 1400
    chk_outs("R2 wrapped slow", 1, 0, 1, 1400);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_track();
    t_unlock();
    t_wrap();
    finish_run();
  end

endmodule